// File: doc/BRIEF.md
# Memory Stack Address Unit

This block generates addresses for a stack held in a region of main memory. Three address sources share one memory address bus: a program counter, a data address register and a stack pointer. Outside stack operations, a select input picks the bus source. The program counter is used for instruction fetch and the address register for operand access. A push or pop operation takes the bus for its own use.

The stack grows toward lower addresses. A push first moves the pointer down by one and then writes the data register at the new pointer value. A pop reads the word at the pointer into the data register and then moves the pointer up by one. With the default reset pointer of 4001, the first item goes to 4000 and the second to 3999. The design does not enforce any stack limit. Its only reaction to the floor of the stack region is a warning output, raised when a push writes below the floor.

The memory has a synchronous read: read data appears in the cycle after the address. The data register also has a direct load path, so that a value can be staged before a push.

Top module: `stack_addr_unit`

## Requirements
- R1: Reset puts the pointer at SP_RESET (default 4001) and the data register at zero, with busy and mem_we low.
- R2: When not busy, mem_addr follows addr_sel: 0 selects pc_in, 1 selects ar_in, and 2 or 3 selects the stack pointer.
- R3: A push accepted while idle lowers the pointer by one at the end of its first busy cycle. In its second busy cycle it drives mem_addr with the new pointer, raises mem_we and drives mem_wdata from the data register. From reset, the first push writes address 4000.
- R4: A pop accepted while idle drives mem_addr with the pointer and keeps mem_we low for two cycles. At the end of the second cycle it loads mem_rdata into the data register and raises the pointer by one.
- R5: Items pushed and then popped come back in reverse order.
- R6: busy stays high for exactly two cycles per operation. Any push, pop or dr_load presented while busy is ignored.
- R7: When push and pop are requested in the same idle cycle, the push is performed.
- R8: Pushes continue below SP_FLOOR (default 3000) with no change in behaviour. below_floor is high exactly in a push write cycle whose address is below SP_FLOOR.
- R9: dr_load in an idle cycle with no push or pop loads dr_wdata into the data register by the next cycle.
- R10: mem_we is high only in the write cycle of a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_sel | input | 2 | Bus source select when idle: 0 PC, 1 AR, 2/3 SP |
| pc_in | input | AW | Program counter value |
| ar_in | input | AW | Data address register value |
| push | input | 1 | Start a push |
| pop | input | 1 | Start a pop |
| dr_load | input | 1 | Load the data register from dr_wdata |
| dr_wdata | input | DW | Value for the data register load |
| mem_rdata | input | DW | Memory read data, one cycle after the address |
| mem_addr | output | AW | Shared memory address bus |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| dr_out | output | DW | Data register |
| sp_out | output | AW | Stack pointer |
| busy | output | 1 | Push or pop in progress |
| below_floor | output | 1 | Push writing below the stack floor |

## Verification
The bench builds the unit with SP_RESET set to 3004 and leaves SP_FLOOR at 3000. After only four pushes the pointer reaches the floor, and later pushes write below it. This exercises the warning flag and confirms that pushing continues unchanged, without thousands of pushes. The default address and data widths are kept, so pointer arithmetic is checked at 16 bits.

// File: rtl/stack_addr_unit.sv
module stack_addr_unit #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SP_RESET = 4001,
  parameter int SP_FLOOR = 3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr_sel,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] ar_in,
  input  logic          push,
  input  logic          pop,
  input  logic          dr_load,
  input  logic [DW-1:0] dr_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] dr_out,
  output logic [AW-1:0] sp_out,
  output logic          busy,
  output logic          below_floor
);
  localparam logic [AW-1:0] SP_INIT = AW'(SP_RESET);
  localparam logic [AW-1:0] FLOOR_A = AW'(SP_FLOOR);

  typedef enum logic [2:0] {S_IDLE, S_PDEC, S_PWR, S_ORD, S_ODONE} st_t;

  st_t           st;
  logic [AW-1:0] sp;
  logic [DW-1:0] dr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sp <= SP_INIT;
      dr <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (push)         st <= S_PDEC;
          else if (pop)     st <= S_ORD;
          else if (dr_load) dr <= dr_wdata;
        end
        S_PDEC: begin
          sp <= sp - 1'b1;
          st <= S_PWR;
        end
        S_PWR: st <= S_IDLE;
        S_ORD: st <= S_ODONE;
        S_ODONE: begin
          dr <= mem_rdata;
          sp <= sp + 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign mem_we      = (st == S_PWR);
  assign mem_wdata   = dr;
  assign dr_out      = dr;
  assign sp_out      = sp;
  assign below_floor = mem_we && (sp < FLOOR_A);
  assign mem_addr    = busy ? sp :
                       (addr_sel == 2'd0) ? pc_in :
                       (addr_sel == 2'd1) ? ar_in : sp;

  a_r3_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PDEC) |=> (sp_out == $past(sp_out) - 1'b1));

  a_r4_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ODONE) |=> (sp_out == $past(sp_out) + 1'b1) && (dr_out == $past(mem_rdata)));

  a_r6_busy_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 !busy);

  a_r6_idle_sp_held: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(sp_out));

  a_r10_we_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(busy));

  a_r8_floor_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    below_floor |-> mem_we && busy);
endmodule

// File: tb/stack_addr_unit_bench.sv
module stack_addr_unit_bench;
  localparam int AW = 16, DW = 16, SPR = 3004, FLR = 3000;

  logic clk = 0, rst_n = 0;
  logic [1:0] addr_sel = 0;
  logic [AW-1:0] pc_in = 16'h0100, ar_in = 16'h0200;
  logic push = 0, pop = 0, dr_load = 0;
  logic [DW-1:0] dr_wdata = 0, mem_rdata = 0;
  logic [AW-1:0] mem_addr, sp_out;
  logic mem_we, busy, below_floor;
  logic [DW-1:0] mem_wdata, dr_out;

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [int];

  int mph = 0, msp = SPR;
  logic [DW-1:0] mdr = 0;
  logic [DW-1:0] q[$];

  always #4 clk = ~clk;

  stack_addr_unit #(.AW(AW), .DW(DW), .SP_RESET(SPR), .SP_FLOOR(FLR)) u_stack_addr_unit (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .pc_in(pc_in), .ar_in(ar_in),
    .push(push), .pop(pop), .dr_load(dr_load), .dr_wdata(dr_wdata), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .dr_out(dr_out),
    .sp_out(sp_out), .busy(busy), .below_floor(below_floor));

  always @(posedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; msp = SPR; mdr = 0; q.delete();
    end else begin
      case (mph)
        0: if (push) mph = 1; else if (pop) mph = 3; else if (dr_load) mdr = dr_wdata;
        1: begin msp = msp - 1; mph = 2; end
        2: begin q.push_back(mdr); mph = 0; end
        3: mph = 4;
        default: begin
          if (q.size() > 0) mdr = q.pop_back();
          msp = msp + 1; mph = 0;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #6;
    if (rst_n) begin
      int ea;
      ea = (mph != 0) ? msp : (addr_sel == 0) ? int'(pc_in) : (addr_sel == 1) ? int'(ar_in) : msp;
      chk(busy == (mph != 0), "R6 busy", busy, mph != 0);
      chk(int'(sp_out) == msp, "R3 R4 pointer", sp_out, msp);
      chk(dr_out == mdr, "R5 data register", dr_out, mdr);
      chk(mem_we == (mph == 2), "R10 write enable", mem_we, mph == 2);
      chk(int'(mem_addr) == ea, "R2 address bus", mem_addr, ea);
      chk(below_floor == (mph == 2 && msp < FLR), "R8 floor flag", below_floor, mph == 2 && msp < FLR);
      if (mph == 2) chk(mem_wdata == mdr, "R3 write data", mem_wdata, mdr);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [DW-1:0] v);
    dr_load = 1; dr_wdata = v; cyc(1); dr_load = 0;
  endtask

  task automatic do_push();
    push = 1; cyc(1); push = 0; cyc(2);
  endtask

  task automatic do_pop();
    pop = 1; cyc(1); pop = 0; cyc(2);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    cyc(3);
    chk(int'(sp_out) == SPR && dr_out == 0 && !busy && !mem_we, "R1 reset", sp_out, SPR);
    rst_n = 1;
    cyc(1);
    for (int s = 0; s < 4; s++) begin addr_sel = s[1:0]; cyc(1); end
    addr_sel = 0;
    load(16'hA001);
    chk(dr_out == 16'hA001, "R9 load", dr_out, 16'hA001);
    do_push();
    chk(mem.exists(SPR - 1) && mem[SPR - 1] == 16'hA001, "R3 first slot", SPR - 1, SPR - 1);
    load(16'hA002); do_push();
    load(16'hA003); push = 1; cyc(1); push = 0;
    pop = 1; dr_load = 1; dr_wdata = 16'hDEAD; cyc(1); pop = 0; dr_load = 0; cyc(1);
    chk(dr_out == 16'hA003 && int'(sp_out) == SPR - 3, "R6 ignored while busy", dr_out, 16'hA003);
    do_pop();
    chk(dr_out == 16'hA003, "R4 pop value", dr_out, 16'hA003);
    do_pop();
    chk(dr_out == 16'hA002, "R5 reverse order", dr_out, 16'hA002);
    load(16'hB000);
    push = 1; pop = 1; cyc(1); push = 0; pop = 0; cyc(2);
    chk(int'(sp_out) == SPR - 2, "R7 push wins", sp_out, SPR - 2);
    for (int i = 0; i < 6; i++) begin load(16'hC000 + 16'(i)); do_push(); end
    chk(int'(sp_out) == SPR - 8, "R8 no limit", sp_out, SPR - 8);
    chk(mem.exists(FLR - 4) && mem[FLR - 4] == 16'hC005, "R8 write below floor", FLR - 4, FLR - 4);
    for (int i = 0; i < 8; i++) do_pop();
    chk(dr_out == 16'hA001 && int'(sp_out) == SPR, "R5 drained", dr_out, 16'hA001);
    addr_sel = 1; ar_in = 16'h1234; cyc(2);
    chk(mem_addr == 16'h1234, "R2 operand source", mem_addr, 16'h1234);
    finish_run();
  end
endmodule